// File: doc/BRIEF.md
# Variable-Count Byte Stream Packer

This block turns a stream of partially filled input words into a stream of dense output words. Each input transfer carries a fixed number of byte lanes, and a separate count says how many lanes at the top of the word are unused. The packer keeps only the used lanes and appends them, in arrival order, to a small holding buffer. Each time the buffer reaches a full word, it emits that word with a one-cycle valid pulse.

One transfer can finish the current output word and also leave bytes over for the next one. Those surplus bytes stay in the buffer and lead the following word. A flush input lets the source close off a partial word at the end of a packet: the packer emits what it holds, with the unused top lanes zeroed. The block applies no backpressure. The source must accept one output word per cycle whenever a word is produced.

Top module: `byte_stream_packer`

## Requirements
- R1: After a synchronous active-high reset, `out_vld` is 0, `out_data` is all zeros and the buffer holds no bytes.
- R2: Byte lane i of `in_data` occupies bits 8i+7:8i. A transfer keeps only lanes 0 to 15 − `in_empty`. Lanes above that are ignored and never reach an output word.
- R3: Each accepted transfer advances the fill position by 16 − `in_empty`, wrapping modulo 16. With `in_empty` = 15 it advances by exactly one, so sixteen single-byte transfers produce exactly one word, on the sixteenth.
- R4: An output word is produced when the held byte count reaches 16 or more. Its bytes are in arrival order, with the earliest byte in lane 0 (bits 7:0).
- R5: `out_vld` is high for the single cycle after the transfer or flush that produced the word, and low in every other cycle.
- R6: Bytes beyond the sixteenth are kept in arrival order and form the start of the next output word.
- R7: A full transfer (`in_empty` = 0) arriving with an empty buffer appears unchanged as one output word in the next cycle and leaves nothing pending.
- R8: A flush in a cycle with `in_vld` low emits the held bytes in lanes 0 upward, with the remaining lanes zero, and empties the buffer. A flush with an empty buffer emits nothing. A flush in the same cycle as `in_vld` is ignored, and the transfer is handled normally.
- R9: In a cycle with `in_vld` and `flush` both low, `in_data` and `in_empty` are ignored and the held bytes are unchanged.
- R10: A reset in the middle of a stream discards the held bytes. The next full transfer then passes through unchanged.
- R11: While `out_vld` is low, `out_data` keeps the last word emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input transfer strobe |
| in_empty | input | 4 | Count of unused lanes at the top of `in_data` |
| in_data | input | 128 | Sixteen input byte lanes, lane 0 lowest |
| flush | input | 1 | Emit a partial word now (only when `in_vld` is low) |
| out_vld | output | 1 | One-cycle strobe marking a new output word |
| out_data | output | 128 | Packed output word, earliest byte in lane 0 |

## Verification
The bound checker watches several properties on every cycle:
- the fill position steps by the valid count modulo 16 on each transfer;
- idle cycles raise no output and leave the fill unchanged;
- a flush empties the fill;
- a full transfer into an empty buffer comes out unchanged;
- `out_data` holds its value between pulses;
- reset clears the block.

Byte ordering across word boundaries, the zero padding of a flushed word, the exact cycle in which the sixteenth byte completes a word, and the fact that ignored lanes never leak into a word depend on the history of the stream. Only the directed scenarios show these, compared against a byte-queue model in the bench.

// File: rtl/spk_pkg.sv
package spk_pkg;
   // Operation selected for the current cycle
   typedef enum logic [1:0] {
      OP_IDLE   = 2'd0,
      OP_ACCEPT = 2'd1,
      OP_FLUSH  = 2'd2
   } spk_op_e;
endpackage

// File: rtl/spk_fill_ctrl.sv
module spk_fill_ctrl #(
   parameter int SYMS     = 16,
   parameter int FLUSH_EN = 1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_vld,
   input  logic [$clog2(SYMS)-1:0]  in_empty,
   input  logic                     flush,
   output logic [$clog2(SYMS)-1:0]  fill_q,
   output logic [$clog2(SYMS):0]    in_cnt,
   output logic                     word_done,
   output spk_pkg::spk_op_e         op
);
   localparam int FILL_W = $clog2(SYMS);
   localparam int CNT_W  = FILL_W + 1;

   logic [CNT_W-1:0] sum;
   logic             flush_req;

   // Valid lane count; lane 0 is always valid
   assign in_cnt    = CNT_W'(SYMS) - CNT_W'(in_empty);
   assign sum       = CNT_W'(fill_q) + in_cnt;
   assign word_done = sum[FILL_W];

   generate
      if (FLUSH_EN != 0) begin : g_flush
         assign flush_req = flush & ~in_vld;
      end else begin : g_noflush
         logic unused_flush;
         assign unused_flush = flush;
         assign flush_req    = 1'b0;
      end
   endgenerate

   always_comb begin
      if (in_vld)         op = spk_pkg::OP_ACCEPT;
      else if (flush_req) op = spk_pkg::OP_FLUSH;
      else                op = spk_pkg::OP_IDLE;
   end

   // Fill position wraps by natural rollover of the low bits
   always_ff @(posedge clk) begin
      if (rst) begin
         fill_q <= '0;
      end else begin
         case (op)
            spk_pkg::OP_ACCEPT: fill_q <= sum[FILL_W-1:0];
            spk_pkg::OP_FLUSH:  fill_q <= '0;
            default:            fill_q <= fill_q;
         endcase
      end
   end
endmodule

// File: rtl/spk_lane_merge.sv
module spk_lane_merge #(
   parameter int SYM_W = 8,
   parameter int SYMS  = 16
) (
   input  logic [$clog2(SYMS)-1:0]   fill_q,
   input  logic [$clog2(SYMS):0]     in_cnt,
   input  logic [SYM_W*SYMS-1:0]     pend_q,
   input  logic [SYM_W*SYMS-1:0]     in_data,
   output logic [2*SYM_W*SYMS-1:0]   merged
);
   localparam int FILL_W = $clog2(SYMS);
   localparam int CNT_W  = FILL_W + 1;
   localparam int LANES  = 2 * SYMS;

   logic [SYM_W-1:0] in_sym [SYMS];

   generate
      for (genvar s = 0; s < SYMS; s++) begin : g_split
         assign in_sym[s] = in_data[s*SYM_W +: SYM_W];
      end

      // Each lane takes a held byte below the fill position,
      // a new byte inside the valid window, or zero.
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         logic [CNT_W-1:0] src;
         logic [SYM_W-1:0] lane_v;
         assign src = CNT_W'(k) - CNT_W'(fill_q);
         if (k < SYMS) begin : g_low
            always_comb begin
               if (CNT_W'(k) < CNT_W'(fill_q))
                  lane_v = pend_q[k*SYM_W +: SYM_W];
               else if (src < in_cnt)
                  lane_v = in_sym[src[FILL_W-1:0]];
               else
                  lane_v = '0;
            end
         end else begin : g_high
            always_comb begin
               if (src < in_cnt) lane_v = in_sym[src[FILL_W-1:0]];
               else              lane_v = '0;
            end
         end
         assign merged[k*SYM_W +: SYM_W] = lane_v;
      end
   endgenerate
endmodule

// File: rtl/byte_stream_packer.sv
module byte_stream_packer #(
   parameter int SYM_W    = 8,
   parameter int SYMS     = 16,
   parameter int FLUSH_EN = 1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_vld,
   input  logic [$clog2(SYMS)-1:0]  in_empty,
   input  logic [SYM_W*SYMS-1:0]    in_data,
   input  logic                     flush,
   output logic                     out_vld,
   output logic [SYM_W*SYMS-1:0]    out_data
);
   localparam int FILL_W = $clog2(SYMS);
   localparam int CNT_W  = FILL_W + 1;
   localparam int WORD_W = SYM_W * SYMS;

   generate
      if (SYMS < 2 || (SYMS & (SYMS - 1)) != 0) begin : g_bad_syms
         $error("SYMS must be a power of two of at least 2");
      end
      if (SYM_W < 1) begin : g_bad_symw
         $error("SYM_W must be positive");
      end
   endgenerate

   logic [FILL_W-1:0]   fill_q;
   logic [CNT_W-1:0]    in_cnt;
   logic                word_done;
   spk_pkg::spk_op_e    op;
   logic [WORD_W-1:0]   pend_q;
   logic [2*WORD_W-1:0] merged;

   spk_fill_ctrl #(.SYMS(SYMS), .FLUSH_EN(FLUSH_EN)) u_fill (
      .clk       (clk),
      .rst       (rst),
      .in_vld    (in_vld),
      .in_empty  (in_empty),
      .flush     (flush),
      .fill_q    (fill_q),
      .in_cnt    (in_cnt),
      .word_done (word_done),
      .op        (op)
   );

   spk_lane_merge #(.SYM_W(SYM_W), .SYMS(SYMS)) u_merge (
      .fill_q  (fill_q),
      .in_cnt  (in_cnt),
      .pend_q  (pend_q),
      .in_data (in_data),
      .merged  (merged)
   );

   // Lanes at and above the fill position of pend_q are always zero,
   // so a flushed word needs no extra masking.
   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q   <= '0;
         out_data <= '0;
         out_vld  <= 1'b0;
      end else begin
         case (op)
            spk_pkg::OP_ACCEPT: begin
               if (word_done) begin
                  out_data <= merged[WORD_W-1:0];
                  pend_q   <= merged[2*WORD_W-1:WORD_W];
                  out_vld  <= 1'b1;
               end else begin
                  pend_q   <= merged[WORD_W-1:0];
                  out_vld  <= 1'b0;
               end
            end
            spk_pkg::OP_FLUSH: begin
               if (fill_q != '0) out_data <= pend_q;
               out_vld <= (fill_q != '0);
               pend_q  <= '0;
            end
            default: out_vld <= 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/spk_checker.sv
module spk_checker #(
   parameter int SYM_W    = 8,
   parameter int SYMS     = 16,
   parameter int FLUSH_EN = 1
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     in_vld,
   input logic [$clog2(SYMS)-1:0]  in_empty,
   input logic [SYM_W*SYMS-1:0]    in_data,
   input logic                     flush,
   input logic                     out_vld,
   input logic [SYM_W*SYMS-1:0]    out_data,
   input logic [$clog2(SYMS)-1:0]  fill_q
);
   localparam int FILL_W = $clog2(SYMS);

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (!out_vld && fill_q == '0 && out_data == '0));

   assert_fill_step_R3: assert property (@(posedge clk) disable iff (rst)
      in_vld |=> fill_q == FILL_W'(int'($past(fill_q)) + SYMS - int'($past(in_empty))));

   assert_pass_through_R7: assert property (@(posedge clk) disable iff (rst)
      (in_vld && in_empty == '0 && fill_q == '0) |=> (out_vld && out_data == $past(in_data)));

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      (!in_vld && !flush) |=> (!out_vld && $stable(fill_q)));

   assert_data_hold_R11: assert property (@(posedge clk) disable iff (rst)
      (!out_vld && !$past(rst)) |-> $stable(out_data));

   generate
      if (FLUSH_EN != 0) begin : g_flush_chk
         assert_flush_clear_R8: assert property (@(posedge clk) disable iff (rst)
            (flush && !in_vld) |=> fill_q == '0);
      end
   endgenerate
endmodule

bind byte_stream_packer spk_checker #(
   .SYM_W(SYM_W), .SYMS(SYMS), .FLUSH_EN(FLUSH_EN)
) u_spk_chk (
   .clk      (clk),
   .rst      (rst),
   .in_vld   (in_vld),
   .in_empty (in_empty),
   .in_data  (in_data),
   .flush    (flush),
   .out_vld  (out_vld),
   .out_data (out_data),
   .fill_q   (fill_q)
);

// File: tb/tb_byte_stream_packer.sv
`timescale 1ns/1ps
module tb_byte_stream_packer;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_vld = 1'b0;
   logic [3:0]   in_empty = '0;
   logic [127:0] in_data = '0;
   logic         flush = 1'b0;
   logic         out_vld;
   logic [127:0] out_data;

   logic [7:0]   q[$];
   logic [127:0] last_out = '0;
   int           total = 0;
   int           bad = 0;
   bit           done = 1'b0;

   always #2 clk = ~clk;

   byte_stream_packer dut (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_empty(in_empty),
      .in_data(in_data), .flush(flush), .out_vld(out_vld), .out_data(out_data)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [127:0] pat(input logic [7:0] seed);
      logic [127:0] w;
      for (int i = 0; i < 16; i++) w[8*i +: 8] = seed + 8'(i * 29) + 8'h11;
      return w;
   endfunction

   // Compare outputs against the byte-queue model
   task automatic expect_out(input string tag);
      logic [127:0] exp;
      if (q.size() >= 16) begin
         for (int i = 0; i < 16; i++) exp[8*i +: 8] = q.pop_front();
         chk(out_vld == 1'b1, tag, "word strobe", 128'(out_vld), 128'd1);
         chk(out_data == exp, tag, "word data", out_data, exp);
         last_out = exp;
      end else begin
         chk(out_vld == 1'b0, tag, "no strobe", 128'(out_vld), 128'd0);
         chk(out_data == last_out, {tag, "/R11"}, "held data", out_data, last_out);
      end
   endtask

   task automatic xfer(input logic [3:0] e, input logic [127:0] d,
                       input logic fl, input string tag);
      @(negedge clk);
      in_vld = 1'b1; in_empty = e; in_data = d; flush = fl;
      @(posedge clk); #1;
      for (int i = 0; i < 16 - int'(e); i++) q.push_back(d[8*i +: 8]);
      expect_out(tag);
   endtask

   task automatic idle(input int n, input string tag);
      for (int c = 0; c < n; c++) begin
         @(negedge clk);
         in_vld = 1'b0; flush = 1'b0; in_empty = 4'(c + 3); in_data = pat(8'(200 + c));
         @(posedge clk); #1;
         expect_out(tag);
      end
   endtask

   task automatic do_flush(input string tag);
      logic [127:0] exp;
      @(negedge clk);
      in_vld = 1'b0; flush = 1'b1;
      @(posedge clk); #1;
      if (q.size() > 0) begin
         exp = '0;
         for (int i = 0; q.size() > 0; i++) exp[8*i +: 8] = q.pop_front();
         chk(out_vld == 1'b1, tag, "flush strobe", 128'(out_vld), 128'd1);
         chk(out_data == exp, tag, "flush data", out_data, exp);
         last_out = exp;
      end else begin
         chk(out_vld == 1'b0, tag, "empty flush strobe", 128'(out_vld), 128'd0);
         chk(out_data == last_out, tag, "empty flush data", out_data, last_out);
      end
   endtask

   task automatic do_reset(input string tag);
      @(negedge clk);
      rst = 1'b1; in_vld = 1'b0; flush = 1'b0;
      @(posedge clk); @(posedge clk); #1;
      q.delete();
      last_out = '0;
      chk(out_vld == 1'b0, tag, "reset strobe", 128'(out_vld), 128'd0);
      chk(out_data == '0, tag, "reset data", out_data, 128'd0);
      @(negedge clk);
      rst = 1'b0;
   endtask

   // R7: full word into empty buffer, nothing left to flush
   task automatic t_pass;
      xfer(4'd0, pat(8'd1), 1'b0, "R7");
      do_flush("R7");
   endtask

   // R3 and R2: single-byte transfers with junk in the unused lanes
   task automatic t_single;
      for (int i = 0; i < 16; i++) xfer(4'd15, pat(8'(40 + i)), 1'b0, "R3");
   endtask

   // R6 and R4: straddling transfers and back-to-back full words
   task automatic t_straddle;
      xfer(4'd6, pat(8'd60), 1'b0, "R2");
      xfer(4'd4, pat(8'd70), 1'b0, "R6");
      xfer(4'd6, pat(8'd80), 1'b0, "R6");
      xfer(4'd13, pat(8'd90), 1'b0, "R4");
      for (int i = 0; i < 3; i++) xfer(4'd0, pat(8'(100 + i)), 1'b0, "R4");
      xfer(4'd3, pat(8'd110), 1'b0, "R6");
   endtask

   // R9 and R5: idle cycles between and after transfers
   task automatic t_idle;
      xfer(4'd10, pat(8'd120), 1'b0, "R9");
      idle(3, "R9");
      xfer(4'd6, pat(8'd130), 1'b0, "R9");
      xfer(4'd0, pat(8'd140), 1'b0, "R5");
      idle(2, "R5");
   endtask

   // R8: flush of a partial word and flush colliding with a transfer
   task automatic t_flush;
      xfer(4'd11, pat(8'd150), 1'b0, "R8");
      do_flush("R8");
      xfer(4'd12, pat(8'd160), 1'b1, "R8");
      idle(1, "R8");
      do_flush("R8");
      do_flush("R8");
   endtask

   // R10: reset mid-stream drops held bytes
   task automatic t_reset_mid;
      xfer(4'd9, pat(8'd170), 1'b0, "R10");
      do_reset("R10");
      xfer(4'd0, pat(8'd180), 1'b0, "R10");
      idle(1, "R10");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      do_reset("R1");
      t_pass();
      t_single();
      t_straddle();
      t_idle();
      t_flush();
      t_reset_mid();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule